// File: doc/BRIEF.md
# Host and Core Mailbox Unit

This block sits between a host processor and an accelerator core and carries 32-bit words both ways through three small queues. Two single-word outbound holders pass words from the core to the host: a plain one and one meant for interrupt-style messages. An inbound queue of four words passes words from the host to the core. A single packed status word shows the fill state of all three queues at once. The core deposits outbound words, drains inbound words in arrival order and sees one-cycle event pulses whenever the host consumes or supplies a word.

The host talks to the block through one request port with a valid/ready handshake. Each request is one of four operations: read the plain outbound holder, read the interrupt outbound holder, write the inbound queue, or poll for readiness. The response follows one cycle later and carries an accept flag that tells whether a whole word moved. When a host access finds nothing to read or no space to write, the block arms the matching interrupt enable so the host can sleep until the condition changes. A small two-state machine sequences the host port. In `HS_IDLE` it is ready, and any request moves it to `HS_RESP`. `HS_RESP` presents the response for one cycle and always returns to `HS_IDLE`.

Top module: `mbox_unit`

## Requirements
- R1: After synchronous reset, status_word equals 32'h0000_0400, host_req_ready is 1, no response or event is asserted, and every interrupt enable, pending bit and channel flag is 0.
- R2: status_word packs the plain outbound count in bits [7:0], the inbound free count in bits [15:8] and the interrupt outbound count in bits [23:16], with bits [31:24] zero. Each outbound holder keeps at most one word, so its count is 0 or 1. A core push into a full holder is ignored and the stored word is kept.
- R3: The inbound free count always equals 4 minus the number of stored words. The core reads words in the order the host wrote them (core_in_data shows the oldest word while core_in_valid is 1). Each core pop raises the free count by one.
- R4: Operation code 0 on a full plain holder returns the word with accept 1, clears bits [7:0], pulses evt_out_taken for one cycle and sets chan_out_avail. chan_out_avail stays 1 until the core's next accepted push into that holder.
- R5: Operation code 1 on a full interrupt holder behaves the same way, using bits [23:16], evt_irq_taken and chan_irq_avail.
- R6: A read of an empty holder returns accept 0 with data 0 and pulses no event. A read of the empty interrupt holder also sets irq_mbox_en, and a read of the empty plain holder leaves it unchanged.
- R7: Operation code 2 with a non-zero free count stores host_req_wdata, lowers the free count by one, pulses evt_in_written and returns accept 1. With a free count of zero it returns accept 0, stores nothing, pulses no event and sets irq_thresh_en.
- R8: Operation code 3 (poll) returns accept 0 and data bit 0 = host_poll_rd AND interrupt holder full, and data bit 1 = host_poll_wr AND free count non-zero. If host_poll_rd is set and the interrupt holder is empty, the poll clears irq_mbox_pend and sets irq_mbox_en. If host_poll_wr is set and the free count is zero, it clears irq_thresh_pend and sets irq_thresh_en.
- R9: irq_mbox_pend is set by an accepted core push into the interrupt holder, and irq_thresh_pend is set by a core pop of a stored word. A set in the same cycle as a poll clear wins.
- R10: A request is taken on a clock edge where host_req_valid and host_req_ready are both 1. In the next cycle host_rsp_valid is 1 for exactly one cycle, host_req_ready is 0, and the status word and event pulses already show the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req_valid | input | 1 | Host request present |
| host_req_op | input | 2 | 0 read plain, 1 read interrupt, 2 write inbound, 3 poll |
| host_req_wdata | input | DW | Word for an inbound write |
| host_poll_rd | input | 1 | Poll asks about readable interrupt data |
| host_poll_wr | input | 1 | Poll asks about inbound space |
| host_req_ready | output | 1 | Port can take a request |
| host_rsp_valid | output | 1 | Response present |
| host_rsp_accept | output | 1 | A whole word was transferred |
| host_rsp_data | output | DW | Read word or poll readiness bits |
| status_word | output | 32 | Packed occupancy of all three queues |
| core_out_push | input | 1 | Core deposits a plain outbound word |
| core_out_data | input | DW | Plain outbound word |
| core_irq_push | input | 1 | Core deposits an interrupt outbound word |
| core_irq_data | input | DW | Interrupt outbound word |
| core_in_pop | input | 1 | Core removes the oldest inbound word |
| core_in_valid | output | 1 | Inbound queue holds a word |
| core_in_data | output | DW | Oldest inbound word |
| chan_out_avail | output | 1 | Plain holder was drained by the host |
| chan_irq_avail | output | 1 | Interrupt holder was drained by the host |
| evt_out_taken | output | 1 | Pulse: host read the plain holder |
| evt_irq_taken | output | 1 | Pulse: host read the interrupt holder |
| evt_in_written | output | 1 | Pulse: host wrote the inbound queue |
| irq_mbox_en | output | 1 | Enable for readable-data interrupt |
| irq_mbox_pend | output | 1 | Readable-data interrupt pending |
| irq_thresh_en | output | 1 | Enable for write-space interrupt |
| irq_thresh_pend | output | 1 | Write-space interrupt pending |

## Verification
A wrong queue pointer or count shows up in the status word on the cycle right after the access, and in core_in_data as soon as the core pops. So the bench compares every field after each step against an arithmetic model rather than waiting for a later read. A stuck or skipped state in the host sequencer shows in host_req_ready and host_rsp_valid within one cycle of the request. A missing enable or pending update shows on the dedicated interrupt pins at the same edge as the poll or access that should have caused it. The poll sweep covers every mix of request bits and queue fill, with a reset before each case.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    typedef enum logic [1:0] {
        OP_RD_OUT = 2'd0,
        OP_RD_IRQ = 2'd1,
        OP_WR_IN  = 2'd2,
        OP_POLL   = 2'd3
    } host_op_e;

    typedef enum logic {
        HS_IDLE = 1'b0,
        HS_RESP = 1'b1
    } host_state_e;

    localparam int FIELD_W = 8;

    function automatic logic [31:0] pack_status(
        input logic [FIELD_W-1:0] out_cnt,
        input logic [FIELD_W-1:0] in_free,
        input logic [FIELD_W-1:0] irq_cnt
    );
        return {8'h00, irq_cnt, in_free, out_cnt};
    endfunction

endpackage

// File: rtl/mbox_slot.sv
module mbox_slot #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] data,
    output logic          chan_avail
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full       <= 1'b0;
            data       <= '0;
            chan_avail <= 1'b0;
        end else if (full) begin
            if (take) begin
                full       <= 1'b0;
                chan_avail <= 1'b1;
            end
        end else if (push) begin
            full       <= 1'b1;
            data       <= push_data;
            chan_avail <= 1'b0;
        end
    end

endmodule

// File: rtl/mbox_inq.sv
module mbox_inq #(
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [DW-1:0]              wr_data,
    input  logic                       pop,
    output logic                       head_valid,
    output logic [DW-1:0]              head,
    output logic [$clog2(DEPTH+1)-1:0] free
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] count;
    logic          do_wr;
    logic          do_pop;

    assign do_wr      = wr_en && (count != FULL);
    assign do_pop     = pop && (count != '0);
    assign head_valid = (count != '0);
    assign head       = mem[rd_ptr];
    assign free       = FULL - count;

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({do_wr, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/mbox_host_fsm.sv
module mbox_host_fsm
    import mbox_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic          poll_rd,
    input  logic          poll_wr,
    input  logic          out_full,
    input  logic [DW-1:0] out_data,
    input  logic          irq_full,
    input  logic [DW-1:0] irq_data,
    input  logic [CW-1:0] in_free,
    output logic          req_ready,
    output logic          take_out,
    output logic          take_irq,
    output logic          wr_in,
    output logic          clr_pend_mbox,
    output logic          set_en_mbox,
    output logic          clr_pend_thresh,
    output logic          set_en_thresh,
    output logic          rsp_valid,
    output logic          rsp_accept,
    output logic [DW-1:0] rsp_data,
    output logic          evt_out,
    output logic          evt_irq,
    output logic          evt_in
);

    host_state_e   state_q;
    host_state_e   state_d;
    host_op_e      op;
    logic          fire;
    logic          has_space;
    logic          nxt_accept;
    logic [DW-1:0] nxt_data;

    assign op        = host_op_e'(req_op);
    assign req_ready = (state_q == HS_IDLE);
    assign fire      = req_valid && req_ready;
    assign has_space = (in_free != '0);

    // Access decode: strobes act on the edge that takes the request
    always_comb begin
        take_out        = 1'b0;
        take_irq        = 1'b0;
        wr_in           = 1'b0;
        clr_pend_mbox   = 1'b0;
        set_en_mbox     = 1'b0;
        clr_pend_thresh = 1'b0;
        set_en_thresh   = 1'b0;
        nxt_accept      = 1'b0;
        nxt_data        = '0;
        if (fire) begin
            unique case (op)
                OP_RD_OUT: begin
                    if (out_full) begin
                        take_out   = 1'b1;
                        nxt_accept = 1'b1;
                        nxt_data   = out_data;
                    end
                end
                OP_RD_IRQ: begin
                    if (irq_full) begin
                        take_irq   = 1'b1;
                        nxt_accept = 1'b1;
                        nxt_data   = irq_data;
                    end else begin
                        set_en_mbox = 1'b1;
                    end
                end
                OP_WR_IN: begin
                    if (has_space) begin
                        wr_in      = 1'b1;
                        nxt_accept = 1'b1;
                    end else begin
                        set_en_thresh = 1'b1;
                    end
                end
                OP_POLL: begin
                    nxt_data[0] = poll_rd && irq_full;
                    nxt_data[1] = poll_wr && has_space;
                    if (poll_rd && !irq_full) begin
                        clr_pend_mbox = 1'b1;
                        set_en_mbox   = 1'b1;
                    end
                    if (poll_wr && !has_space) begin
                        clr_pend_thresh = 1'b1;
                        set_en_thresh   = 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            HS_IDLE: state_d = fire ? HS_RESP : HS_IDLE;
            HS_RESP: state_d = HS_IDLE;
            default: state_d = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_accept <= 1'b0;
            rsp_data   <= '0;
            evt_out    <= 1'b0;
            evt_irq    <= 1'b0;
            evt_in     <= 1'b0;
        end else begin
            rsp_valid  <= fire;
            rsp_accept <= nxt_accept;
            rsp_data   <= nxt_data;
            evt_out    <= take_out;
            evt_irq    <= take_irq;
            evt_in     <= wr_in;
        end
    end

endmodule

// File: rtl/mbox_unit.sv
module mbox_unit
    import mbox_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_req_valid,
    input  logic [1:0]    host_req_op,
    input  logic [DW-1:0] host_req_wdata,
    input  logic          host_poll_rd,
    input  logic          host_poll_wr,
    output logic          host_req_ready,
    output logic          host_rsp_valid,
    output logic          host_rsp_accept,
    output logic [DW-1:0] host_rsp_data,
    output logic [31:0]   status_word,
    input  logic          core_out_push,
    input  logic [DW-1:0] core_out_data,
    input  logic          core_irq_push,
    input  logic [DW-1:0] core_irq_data,
    input  logic          core_in_pop,
    output logic          core_in_valid,
    output logic [DW-1:0] core_in_data,
    output logic          chan_out_avail,
    output logic          chan_irq_avail,
    output logic          evt_out_taken,
    output logic          evt_irq_taken,
    output logic          evt_in_written,
    output logic          irq_mbox_en,
    output logic          irq_mbox_pend,
    output logic          irq_thresh_en,
    output logic          irq_thresh_pend
);

    localparam int CW     = $clog2(DEPTH + 1);
    localparam int NSLOTS = 2;

    // slot 0 = plain outbound holder, slot 1 = interrupt outbound holder
    logic          slot_push  [NSLOTS];
    logic [DW-1:0] slot_wdata [NSLOTS];
    logic          slot_take  [NSLOTS];
    logic          slot_full  [NSLOTS];
    logic [DW-1:0] slot_rdata [NSLOTS];
    logic          slot_chan  [NSLOTS];

    logic          take_out;
    logic          take_irq;
    logic          wr_in;
    logic          clr_pend_mbox;
    logic          set_en_mbox;
    logic          clr_pend_thresh;
    logic          set_en_thresh;
    logic [CW-1:0] in_free;
    logic          irq_push_ok;
    logic          in_pop_ok;

    assign slot_push[0]  = core_out_push;
    assign slot_wdata[0] = core_out_data;
    assign slot_take[0]  = take_out;
    assign slot_push[1]  = core_irq_push;
    assign slot_wdata[1] = core_irq_data;
    assign slot_take[1]  = take_irq;

    for (genvar g = 0; g < NSLOTS; g++) begin : g_slot
        mbox_slot #(.DW(DW)) u_slot (
            .clk        (clk),
            .rst        (rst),
            .push       (slot_push[g]),
            .push_data  (slot_wdata[g]),
            .take       (slot_take[g]),
            .full       (slot_full[g]),
            .data       (slot_rdata[g]),
            .chan_avail (slot_chan[g])
        );
    end

    mbox_inq #(.DW(DW), .DEPTH(DEPTH)) u_inq (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_in),
        .wr_data    (host_req_wdata),
        .pop        (core_in_pop),
        .head_valid (core_in_valid),
        .head       (core_in_data),
        .free       (in_free)
    );

    mbox_host_fsm #(.DW(DW), .CW(CW)) u_fsm (
        .clk             (clk),
        .rst             (rst),
        .req_valid       (host_req_valid),
        .req_op          (host_req_op),
        .poll_rd         (host_poll_rd),
        .poll_wr         (host_poll_wr),
        .out_full        (slot_full[0]),
        .out_data        (slot_rdata[0]),
        .irq_full        (slot_full[1]),
        .irq_data        (slot_rdata[1]),
        .in_free         (in_free),
        .req_ready       (host_req_ready),
        .take_out        (take_out),
        .take_irq        (take_irq),
        .wr_in           (wr_in),
        .clr_pend_mbox   (clr_pend_mbox),
        .set_en_mbox     (set_en_mbox),
        .clr_pend_thresh (clr_pend_thresh),
        .set_en_thresh   (set_en_thresh),
        .rsp_valid       (host_rsp_valid),
        .rsp_accept      (host_rsp_accept),
        .rsp_data        (host_rsp_data),
        .evt_out         (evt_out_taken),
        .evt_irq         (evt_irq_taken),
        .evt_in          (evt_in_written)
    );

    assign irq_push_ok = core_irq_push && !slot_full[1];
    assign in_pop_ok   = core_in_pop && core_in_valid;

    // Interrupt state: a set from the core side outranks a poll clear
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_mbox_en     <= 1'b0;
            irq_mbox_pend   <= 1'b0;
            irq_thresh_en   <= 1'b0;
            irq_thresh_pend <= 1'b0;
        end else begin
            if (set_en_mbox) begin
                irq_mbox_en <= 1'b1;
            end
            if (set_en_thresh) begin
                irq_thresh_en <= 1'b1;
            end
            if (irq_push_ok) begin
                irq_mbox_pend <= 1'b1;
            end else if (clr_pend_mbox) begin
                irq_mbox_pend <= 1'b0;
            end
            if (in_pop_ok) begin
                irq_thresh_pend <= 1'b1;
            end else if (clr_pend_thresh) begin
                irq_thresh_pend <= 1'b0;
            end
        end
    end

    assign chan_out_avail = slot_chan[0];
    assign chan_irq_avail = slot_chan[1];

    assign status_word = pack_status(FIELD_W'(slot_full[0]),
                                     FIELD_W'(in_free),
                                     FIELD_W'(slot_full[1]));

endmodule

// File: rtl/mbox_unit_chk.sv
module mbox_unit_chk #(
    parameter int DEPTH = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        host_req_valid,
    input logic        host_req_ready,
    input logic [1:0]  host_req_op,
    input logic        host_rsp_valid,
    input logic        host_rsp_accept,
    input logic [31:0] status_word,
    input logic        evt_out_taken,
    input logic        evt_irq_taken,
    input logic        evt_in_written,
    input logic        irq_thresh_en,
    input logic        chan_out_avail
);

    logic take_edge;
    assign take_edge = host_req_valid && host_req_ready;

    assert_status_pack_R2: assert property (@(posedge clk) disable iff (rst)
        (status_word[31:24] == 8'h00) && (status_word[7:1] == 7'd0) &&
        (status_word[23:17] == 7'd0));

    assert_free_bound_R3: assert property (@(posedge clk) disable iff (rst)
        status_word[15:8] <= 8'(DEPTH));

    assert_plain_read_R4: assert property (@(posedge clk) disable iff (rst)
        (take_edge && host_req_op == 2'd0 && status_word[0])
        |=> (host_rsp_accept && evt_out_taken && status_word[7:0] == 8'd0 && chan_out_avail));

    assert_write_full_R7: assert property (@(posedge clk) disable iff (rst)
        (take_edge && host_req_op == 2'd2 && status_word[15:8] == 8'd0)
        |=> (!host_rsp_accept && irq_thresh_en && !evt_in_written));

    assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (rst)
        take_edge |=> (host_rsp_valid && !host_req_ready));

    assert_rsp_single_R10: assert property (@(posedge clk) disable iff (rst)
        host_rsp_valid |=> !host_rsp_valid);

    assert_evt_with_rsp_R10: assert property (@(posedge clk) disable iff (rst)
        (evt_out_taken || evt_irq_taken || evt_in_written) |-> (host_rsp_valid && host_rsp_accept));

endmodule

bind mbox_unit mbox_unit_chk #(.DEPTH(DEPTH)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .host_req_valid  (host_req_valid),
    .host_req_ready  (host_req_ready),
    .host_req_op     (host_req_op),
    .host_rsp_valid  (host_rsp_valid),
    .host_rsp_accept (host_rsp_accept),
    .status_word     (status_word),
    .evt_out_taken   (evt_out_taken),
    .evt_irq_taken   (evt_irq_taken),
    .evt_in_written  (evt_in_written),
    .irq_thresh_en   (irq_thresh_en),
    .chan_out_avail  (chan_out_avail)
);

// File: tb/mbox_unit_bench.sv
`timescale 1ns/1ps
module mbox_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req_valid = 1'b0;
    logic [1:0]  host_req_op = 2'd0;
    logic [31:0] host_req_wdata = '0;
    logic        host_poll_rd = 1'b0;
    logic        host_poll_wr = 1'b0;
    logic        host_req_ready;
    logic        host_rsp_valid;
    logic        host_rsp_accept;
    logic [31:0] host_rsp_data;
    logic [31:0] status_word;
    logic        core_out_push = 1'b0;
    logic [31:0] core_out_data = '0;
    logic        core_irq_push = 1'b0;
    logic [31:0] core_irq_data = '0;
    logic        core_in_pop = 1'b0;
    logic        core_in_valid;
    logic [31:0] core_in_data;
    logic        chan_out_avail;
    logic        chan_irq_avail;
    logic        evt_out_taken;
    logic        evt_irq_taken;
    logic        evt_in_written;
    logic        irq_mbox_en;
    logic        irq_mbox_pend;
    logic        irq_thresh_en;
    logic        irq_thresh_pend;

    int checks = 0;
    int errors = 0;

    logic        r_acc;
    logic [31:0] r_data;
    logic        r_evo;
    logic        r_evi;
    logic        r_evw;

    always #4 clk = ~clk;

    mbox_unit #(.DW(32), .DEPTH(4)) u_mbox_unit (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic host_op(input logic [1:0] op, input logic [31:0] wd,
                           input logic prd, input logic pwr,
                           input logic cpush, input logic [31:0] cdata);
        @(negedge clk);
        host_req_valid = 1'b1;
        host_req_op    = op;
        host_req_wdata = wd;
        host_poll_rd   = prd;
        host_poll_wr   = pwr;
        core_irq_push  = cpush;
        core_irq_data  = cdata;
        @(posedge clk);
        #1;
        host_req_valid = 1'b0;
        core_irq_push  = 1'b0;
        r_acc  = host_rsp_accept;
        r_data = host_rsp_data;
        r_evo  = evt_out_taken;
        r_evi  = evt_irq_taken;
        r_evw  = evt_in_written;
        chk("R10 rsp_valid after request", {31'd0, host_rsp_valid}, 32'd1);
        chk("R10 ready low in response", {31'd0, host_req_ready}, 32'd0);
        @(posedge clk);
        #1;
        chk("R10 rsp_valid single cycle", {31'd0, host_rsp_valid}, 32'd0);
    endtask

    task automatic push_out(input logic [31:0] d);
        @(negedge clk);
        core_out_push = 1'b1;
        core_out_data = d;
        @(posedge clk);
        #1;
        core_out_push = 1'b0;
    endtask

    task automatic push_irq(input logic [31:0] d);
        @(negedge clk);
        core_irq_push = 1'b1;
        core_irq_data = d;
        @(posedge clk);
        #1;
        core_irq_push = 1'b0;
    endtask

    task automatic pop_in();
        @(negedge clk);
        core_in_pop = 1'b1;
        @(posedge clk);
        #1;
        core_in_pop = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] q[$];
        logic [31:0] pats [4];
        pats[0] = 32'h0000_0001;
        pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'hA5A5_5A5A;
        pats[3] = 32'h8000_0000;

        // R1 reset state
        do_reset();
        #1;
        chk("R1 status after reset", status_word, 32'h0000_0400);
        chk("R1 ready after reset", {31'd0, host_req_ready}, 32'd1);
        chk("R1 irq bits after reset",
            {28'd0, irq_mbox_en, irq_mbox_pend, irq_thresh_en, irq_thresh_pend}, 32'd0);
        chk("R1 chan flags after reset", {30'd0, chan_out_avail, chan_irq_avail}, 32'd0);

        // R6 empty reads
        host_op(2'd0, 32'd0, 1'b0, 1'b0, 1'b0, 32'd0);
        chk("R6 empty plain accept", {31'd0, r_acc}, 32'd0);
        chk("R6 empty plain data", r_data, 32'd0);
        chk("R6 empty plain no event", {31'd0, r_evo}, 32'd0);
        chk("R6 empty plain leaves enable", {31'd0, irq_mbox_en}, 32'd0);
        host_op(2'd1, 32'd0, 1'b0, 1'b0, 1'b0, 32'd0);
        chk("R6 empty irq accept", {31'd0, r_acc}, 32'd0);
        chk("R6 empty irq no event", {31'd0, r_evi}, 32'd0);
        chk("R6 empty irq sets enable", {31'd0, irq_mbox_en}, 32'd1);

        // R2 R4 R5 outbound holders, several data patterns
        for (int p = 0; p < 4; p++) begin
            for (int s = 0; s < 2; s++) begin
                int sh;
                sh = (s == 0) ? 0 : 16;
                if (s == 0) begin
                    push_out(pats[p]);
                    push_out(~pats[p]);
                end else begin
                    push_irq(pats[p]);
                    push_irq(~pats[p]);
                    chk("R9 irq push sets pending", {31'd0, irq_mbox_pend}, 32'd1);
                end
                chk("R2 holder count one", status_word, 32'h0000_0400 | (32'd1 << sh));
                chk("R4 R5 chan cleared by push",
                    {31'd0, (s == 0) ? chan_out_avail : chan_irq_avail}, 32'd0);
                host_op((s == 0) ? 2'd0 : 2'd1, 32'd0, 1'b0, 1'b0, 1'b0, 32'd0);
                chk("R4 R5 read accept", {31'd0, r_acc}, 32'd1);
                chk("R2 full push ignored, first word kept", r_data, pats[p]);
                chk("R4 R5 count cleared", status_word, 32'h0000_0400);
                chk("R4 R5 event pulse", {30'd0, r_evo, r_evi}, (s == 0) ? 32'd2 : 32'd1);
                chk("R4 R5 event one cycle", {30'd0, evt_out_taken, evt_irq_taken}, 32'd0);
                chk("R4 R5 chan set",
                    {31'd0, (s == 0) ? chan_out_avail : chan_irq_avail}, 32'd1);
                host_op((s == 0) ? 2'd0 : 2'd1, 32'd0, 1'b0, 1'b0, 1'b0, 32'd0);
                chk("R6 reread empty accept", {31'd0, r_acc}, 32'd0);
            end
        end

        // R3 R7 inbound queue, mixed writes and pops against a model
        do_reset();
        for (int i = 0; i < 24; i++) begin
            if ((i % 3) != 2 || q.size() == 0) begin
                logic [31:0] w;
                w = 32'hC000_0000 + i * 32'h0101;
                host_op(2'd2, w, 1'b0, 1'b0, 1'b0, 32'd0);
                if (q.size() < 4) begin
                    q.push_back(w);
                    chk("R7 write accept", {31'd0, r_acc}, 32'd1);
                    chk("R7 write event", {31'd0, r_evw}, 32'd1);
                end else begin
                    chk("R7 full write refused", {31'd0, r_acc}, 32'd0);
                    chk("R7 full write no event", {31'd0, r_evw}, 32'd0);
                    chk("R7 full write sets threshold enable", {31'd0, irq_thresh_en}, 32'd1);
                end
            end else begin
                chk("R3 head valid", {31'd0, core_in_valid}, 32'd1);
                chk("R3 FIFO order", core_in_data, q[0]);
                pop_in();
                void'(q.pop_front());
                chk("R9 pop sets threshold pending", {31'd0, irq_thresh_pend}, 32'd1);
            end
            chk("R3 free count", status_word, 32'(4 - q.size()) << 8);
        end
        // fill to full then drain completely
        while (q.size() < 4) begin
            logic [31:0] w;
            w = 32'h5000_0000 + 32'(q.size());
            host_op(2'd2, w, 1'b0, 1'b0, 1'b0, 32'd0);
            q.push_back(w);
        end
        host_op(2'd2, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0, 32'd0);
        chk("R7 refused at full", {31'd0, r_acc}, 32'd0);
        while (q.size() > 0) begin
            chk("R3 drain order", core_in_data, q[0]);
            pop_in();
            void'(q.pop_front());
            chk("R3 drain free", status_word, 32'(4 - q.size()) << 8);
        end
        chk("R3 empty after drain", {31'd0, core_in_valid}, 32'd0);

        // R8 poll sweep: request bits x queue fill
        for (int c = 0; c < 16; c++) begin
            logic prd, pwr, ifull, qfull;
            prd   = c[0];
            pwr   = c[1];
            ifull = c[2];
            qfull = c[3];
            do_reset();
            push_irq(32'h1234_0000 + c);
            if (!ifull) host_op(2'd1, 32'd0, 1'b0, 1'b0, 1'b0, 32'd0);
            host_op(2'd2, 32'd7, 1'b0, 1'b0, 1'b0, 32'd0);
            pop_in();
            if (qfull) begin
                for (int k = 0; k < 4; k++) host_op(2'd2, 32'(k), 1'b0, 1'b0, 1'b0, 32'd0);
            end
            host_op(2'd3, 32'd0, prd, pwr, 1'b0, 32'd0);
            chk("R8 poll accept", {31'd0, r_acc}, 32'd0);
            chk("R8 poll bits", r_data, {30'd0, pwr & ~qfull, prd & ifull});
            chk("R8 mbox pend", {31'd0, irq_mbox_pend}, {31'd0, ~(prd & ~ifull)});
            chk("R8 mbox en", {31'd0, irq_mbox_en}, {31'd0, prd & ~ifull});
            chk("R8 thresh pend", {31'd0, irq_thresh_pend}, {31'd0, ~(pwr & qfull)});
            chk("R8 thresh en", {31'd0, irq_thresh_en}, {31'd0, pwr & qfull});
        end

        // R9 set beats poll clear in the same cycle
        do_reset();
        push_irq(32'hAAAA_0001);
        host_op(2'd1, 32'd0, 1'b0, 1'b0, 1'b0, 32'd0);
        host_op(2'd3, 32'd0, 1'b1, 1'b0, 1'b1, 32'hBBBB_0002);
        chk("R9 poll sees empty holder", r_data, 32'd0);
        chk("R9 pending set wins", {31'd0, irq_mbox_pend}, 32'd1);
        chk("R9 enable still set", {31'd0, irq_mbox_en}, 32'd1);
        chk("R9 holder filled", status_word, 32'h0001_0400);
        host_op(2'd1, 32'd0, 1'b0, 1'b0, 1'b0, 32'd0);
        chk("R5 collided word delivered", r_data, 32'hBBBB_0002);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule